// File: doc/BRIEF.md
# Resolution-Masked Temperature Capture Register

This block sits between a temperature converter and the serial register interface of a digital thermometer. Each time the converter finishes a measurement it pulses a valid strobe with a 16-bit left-justified two's complement result. The block clears the low-order bits that lie below the resolution chosen in configuration. It then keeps the result in two places.

The first copy is a comparison value. It feeds the alarm logic and always takes the newest result, whatever the bus is doing. The second copy is the value that the serial interface returns to the host. It must not change in the middle of a host read, so a result that completes while a read is in progress is dropped for that copy. It is not held back and applied later.

The resolution code is sampled in the same cycle as the conversion strobe. A new setting therefore affects only conversions that complete after it is written. Values already stored keep the bits they were captured with.

Top module: `tsense_capture`

## Requirements
- R1: Both stored values are 16-bit two's complement with the sign at bit 15 and the magnitude MSB at bit 14; a negative result keeps its sign and upper bits unchanged.
- R2: The resolution code res_sel_i selects how many top bits are kept: 2'b00 keeps 9 bits (step 0.5 °C), 2'b01 keeps 10 bits (0.25 °C), 2'b10 keeps 11 bits (0.125 °C), 2'b11 keeps 12 bits (0.0625 °C). Every bit below the kept field reads as zero, so bits [3:0] are always zero.
- R3: On every cycle in which conv_valid_i is high, cmp_value_o takes the truncated result on the next clock edge, whatever the state of rd_busy_i.
- R4: When conv_valid_i is high and rd_busy_i is low, read_value_o takes the truncated result on the next edge. When rd_busy_i is high, read_value_o keeps its old value, and the dropped result never appears on it afterwards.
- R5: An active-low reset (rst_n) sets cmp_value_o and read_value_o to zero.
- R6: A strobe in the same cycle that rd_busy_i first rises is treated as masked: it updates cmp_value_o but not read_value_o.
- R7: A change of res_sel_i alters no stored value. It applies from the next conversion strobe onward.
- R8: In a cycle with conv_valid_i low, neither output changes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid_i | input | 1 | One-cycle pulse when a conversion result is ready |
| conv_data_i | input | 16 | Left-justified two's complement conversion result |
| res_sel_i | input | 2 | Resolution code (see R2) |
| rd_busy_i | input | 1 | High while a host read of the temperature is in progress |
| cmp_value_o | output | 16 | Truncated newest result for the alarm comparator |
| read_value_o | output | 16 | Truncated result presented to the serial interface |

## Verification
The bench sends strobes while rd_busy_i is high, including the cycle in which it rises. A design that let these through would show read_value_o changing during a read. A design that gated the comparison path as well would leave cmp_value_o stale.

After a masked result, the bench idles with rd_busy_i low. A design that queued the dropped result would then update read_value_o with no strobe present.

The bench changes res_sel_i between strobes. A design that truncated on the output side, or applied the code late, would alter stored values or mask the next result with the wrong width. It also drives negative results at each width, which exposes a mask that drops the sign bit or keeps stray low bits.

// File: rtl/tsense_capture_pkg.sv
package tsense_capture_pkg;

    // Resolution codes: number of kept bits is 9 + code
    typedef enum logic [1:0] {
        RES_HALF      = 2'b00,
        RES_QUARTER   = 2'b01,
        RES_EIGHTH    = 2'b10,
        RES_SIXTEENTH = 2'b11
    } res_code_e;

endpackage

// File: rtl/tsense_trunc.sv
module tsense_trunc #(
    parameter int DATA_W   = 16,
    parameter int MIN_KEEP = 9,
    parameter int SEL_W    = 2
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] trunc_o
);
    localparam int IDX_W = $clog2(DATA_W) + 2;
    localparam logic [IDX_W-1:0] BASE_LSB = IDX_W'(DATA_W - MIN_KEEP);

    logic [IDX_W-1:0] lsb_pos;

    // Position of the lowest kept bit: coarsest setting minus the code
    always_comb begin
        lsb_pos = BASE_LSB - IDX_W'(sel_i);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [IDX_W-1:0] POS = IDX_W'(i);
        assign trunc_o[i] = raw_i[i] & (POS >= lsb_pos);
    end

endmodule

// File: rtl/tsense_hold.sv
module tsense_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_cmp_i,
    input  logic              take_rd_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] cmp_o,
    output logic [DATA_W-1:0] rd_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] rd;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_cmp_i) st_d.cmp = value_i;
        if (take_rd_i)  st_d.rd  = value_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o = st_q.cmp;
    assign rd_o  = st_q.rd;

    // The readable copy only changes at a cycle where the comparison copy also loaded
    assert_rd_needs_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd_i |-> take_cmp_i);

    // After a read-side load, both copies hold the same value
    assert_copies_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_rd_i |=> (rd_o == cmp_o));

endmodule

// File: rtl/tsense_capture.sv
module tsense_capture
    import tsense_capture_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MIN_KEEP = 9,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic [SEL_W-1:0]  res_sel_i,
    input  logic              rd_busy_i,
    output logic [DATA_W-1:0] cmp_value_o,
    output logic [DATA_W-1:0] read_value_o
);
    localparam int MAX_KEEP = MIN_KEEP + (1 << SEL_W) - 1;
    localparam int ZERO_W   = DATA_W - MAX_KEEP;

    logic [DATA_W-1:0] masked;
    logic              take_rd;

    tsense_trunc #(
        .DATA_W   (DATA_W),
        .MIN_KEEP (MIN_KEEP),
        .SEL_W    (SEL_W)
    ) u_trunc (
        .raw_i   (conv_data_i),
        .sel_i   (res_sel_i),
        .trunc_o (masked)
    );

    // A strobe while a read is open (even in its first cycle) is dropped for the host copy
    assign take_rd = conv_valid_i & ~rd_busy_i;

    tsense_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_cmp_i (conv_valid_i),
        .take_rd_i  (take_rd),
        .value_i    (masked),
        .cmp_o      (cmp_value_o),
        .rd_o       (read_value_o)
    );

    assert_busy_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy_i |=> $stable(read_value_o));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid_i |=> ($stable(cmp_value_o) && $stable(read_value_o)));

    assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid_i |=> (cmp_value_o[DATA_W-1] == $past(conv_data_i[DATA_W-1])));

    if (ZERO_W > 0) begin : g_lowzero
        assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_value_o[ZERO_W-1:0] == '0) && (read_value_o[ZERO_W-1:0] == '0));
    end

endmodule

// File: tb/tb_tsense_capture.sv
`timescale 1ns/1ps
module tb_tsense_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid_i = 1'b0;
    logic [15:0] conv_data_i = '0;
    logic [1:0]  res_sel_i = '0;
    logic        rd_busy_i = 1'b0;
    logic [15:0] cmp_value_o, read_value_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] m_cmp = '0;
    logic [15:0] m_rd  = '0;
    string tag = "R5";

    always #5 clk = ~clk;

    tsense_capture dut (
        .clk(clk), .rst_n(rst_n), .conv_valid_i(conv_valid_i),
        .conv_data_i(conv_data_i), .res_sel_i(res_sel_i), .rd_busy_i(rd_busy_i),
        .cmp_value_o(cmp_value_o), .read_value_o(read_value_o)
    );

    function automatic logic [15:0] ref_trunc(logic [15:0] d, logic [1:0] r);
        int shift;
        int v;
        shift = 16 - (9 + int'(r));
        v = int'(d);
        v = (v >> shift) << shift;
        return v[15:0];
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(logic v, logic [15:0] d, logic [1:0] r, logic b);
        conv_valid_i = v; conv_data_i = d; res_sel_i = r; rd_busy_i = b;
        @(posedge clk);
        if (!rst_n) begin
            m_cmp = '0; m_rd = '0;
        end else if (v) begin
            m_cmp = ref_trunc(d, r);
            if (!b) m_rd = ref_trunc(d, r);
        end
        @(negedge clk);
        chk({tag, " cmp"}, cmp_value_o, m_cmp);
        chk({tag, " read"}, read_value_o, m_rd);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1'b1, 16'h7FFF, 2'b11, 1'b0);         // R5: held in reset, data ignored
        rst_n = 1'b1;
        cyc(1'b0, 16'h0, 2'b00, 1'b0);
        chk("R5 reset read", read_value_o, 16'h0000);

        tag = "R1";
        cyc(1'b1, 16'hCDE7, 2'b11, 1'b0);
        chk("R1 negative 12-bit", read_value_o, 16'hCDE0);
        cyc(1'b1, 16'h7D00, 2'b00, 1'b0);
        chk("R1 +125C", read_value_o, 16'h7D00);

        tag = "R2";
        cyc(1'b1, 16'h7FFF, 2'b00, 1'b0);
        chk("R2 9-bit", read_value_o, 16'h7F80);
        cyc(1'b1, 16'h7FFF, 2'b01, 1'b0);
        chk("R2 10-bit", read_value_o, 16'h7FC0);
        cyc(1'b1, 16'h7FFF, 2'b10, 1'b0);
        chk("R2 11-bit", read_value_o, 16'h7FE0);
        cyc(1'b1, 16'h7FFF, 2'b11, 1'b0);
        chk("R2 12-bit", read_value_o, 16'h7FF0);
        cyc(1'b1, 16'hE6F5, 2'b00, 1'b0);
        chk("R2 negative 9-bit", cmp_value_o, 16'hE680);

        tag = "R6";
        cyc(1'b1, 16'h1234, 2'b11, 1'b1);         // strobe in rising cycle of busy
        chk("R6 read held", read_value_o, 16'hE680);
        chk("R6 cmp taken", cmp_value_o, 16'h1230);

        tag = "R3";
        cyc(1'b0, 16'h0, 2'b11, 1'b1);
        cyc(1'b1, 16'h4B00, 2'b11, 1'b1);
        chk("R3 cmp during read", cmp_value_o, 16'h4B00);

        tag = "R4";
        cyc(1'b0, 16'h0, 2'b11, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 16'hFFFF, 2'b11, 1'b0);
        chk("R4 dropped not queued", read_value_o, 16'hE680);
        cyc(1'b1, 16'h0C40, 2'b11, 1'b0);
        chk("R4 next free strobe", read_value_o, 16'h0C40);

        tag = "R7";
        cyc(1'b0, 16'h0, 2'b00, 1'b0);            // coarser code, no strobe
        chk("R7 no re-truncation", read_value_o, 16'h0C40);
        cyc(1'b1, 16'h0C40, 2'b00, 1'b0);
        chk("R7 new code applied", read_value_o, 16'h0C00);

        tag = "R8";
        for (int i = 0; i < 3; i++) cyc(1'b0, 16'h5555, 2'b11, i[0]);
        chk("R8 idle hold", cmp_value_o, 16'h0C00);

        tag = "R3/R4 random";
        for (int i = 0; i < 3000; i++)
            cyc(1'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));

        tag = "R5 mid";
        rst_n = 1'b0;
        cyc(1'b0, 16'h0, 2'b00, 1'b0);
        chk("R5 mid-run reset", cmp_value_o, 16'h0000);
        rst_n = 1'b1;
        cyc(1'b1, 16'hB6A0, 2'b10, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule